// File: doc/BRIEF.md
# Serial Keyboard Receiver with Acknowledge Handshake

This block receives key events from a keyboard controller over a two-wire clocked serial link. The keyboard drives a serial clock that idles high and a data line. The receiver samples one data bit on each rising edge of that clock, most significant bit first, and after eight bits it has a raw byte. The raw byte is active-low and rotated on the wire. The block inverts it and rotates it right by one place. The result is an event byte: a 7-bit key code plus a flag that says whether the key went up or down.

Ordinary key events emit a one-cycle strobe with the code and the release flag, and they update a 128-bit matrix of held keys. A small set of reserved event bytes are status reports rather than keys. They come out on a separate strobe and leave the matrix alone. One of them, the reset warning, also sets a sticky reset-pending output. After every byte the block acknowledges by asking the board to pull the data line low for a timed pulse. The pulse length comes from the system clock rate and a target width in microseconds. While the pulse runs, the serial clock is ignored.

Top module: `kbd_rx`

## Requirements
- R1: While rstN is low, and after it is released with no traffic, evtValid, statValid, kbDatLow and resetPending are 0 and every keyMatrix bit is 0.
- R2: A frame is eight data bits. Each bit is sampled from kbDatIn on a rising edge of kbClkIn, the first bit taken as bit 7 of the raw byte. The frame completes on the eighth rising edge.
- R3: The event byte is the bitwise inverse of the raw byte, rotated right by one bit (raw bit 0 inverted becomes event bit 7). evtRelease is event bit 7 (0 = pressed, 1 = released) and evtCode is event bits 6:0. A key event raises evtValid for exactly one cycle, on the third clock edge after the eighth rising serial edge reaches the pin.
- R4: A press event sets keyMatrix[evtCode] and a release event clears it, on the same edge as evtValid. All other matrix bits are left unchanged.
- R5: Event bytes 0xF9, 0xFA, 0xFC, 0xFD, 0xFE and 0x78 are status codes. Each raises statValid for one cycle, with statCode equal to the event byte and at the same time a key event would appear. evtValid stays 0 and keyMatrix is unchanged.
- R6: Event byte 0x78 sets resetPending on the same edge as statValid. resetPending then stays 1 until rstN is asserted.
- R7: kbDatLow goes to 1 on the same edge as the strobe of each frame. It stays 1 for exactly CLK_KHZ*ACK_US/1000 clock cycles.
- R8: Rising edges on kbClkIn while kbDatLow is 1 shift no data and count no bits. The next frame after the handshake decodes correctly.
- R9: Event bytes with bit 7 set that are not listed in R5 (for example 0xF8, 0xFB, 0xFF, 0x80) are ordinary key releases and clear their matrix bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| kbClkIn | input | 1 | Serial clock from the keyboard, idles high, asynchronous |
| kbDatIn | input | 1 | Serial data from the keyboard, asynchronous |
| kbDatLow | output | 1 | 1 = pull the data line low (acknowledge pulse) |
| evtValid | output | 1 | One-cycle strobe for a key event |
| evtCode | output | 7 | Key code of the last key event |
| evtRelease | output | 1 | 1 = last key event was a release |
| statValid | output | 1 | One-cycle strobe for a status code |
| statCode | output | 8 | Event byte of the last status code |
| keyMatrix | output | 128 | One bit per key code, 1 while held |
| resetPending | output | 1 | Sticky, set by the reset-warning code |

## Verification
Two synchronizer stages and one edge-detect register sit between the pins and the first action. So the strobes, the matrix update, resetPending and the start of kbDatLow are all due on the third clock edge after the eighth rising serial-clock level is applied. The bench drives pins on falling clock edges. It confirms that both strobes are still low at the second falling edge after that eighth edge and checks them at the third. It then counts the falling edges during which kbDatLow is high and compares the count with the computed pulse length. It also toggles the serial clock inside the pulse and checks that the following frame still decodes.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;

  localparam int FRAME_BITS  = 8;
  localparam int KEY_CODE_W  = 7;
  localparam int NUM_KEYS    = 1 << KEY_CODE_W;
  localparam int BIT_CNT_W   = $clog2(FRAME_BITS);

  localparam logic [FRAME_BITS-1:0] CODE_RESET_WARN = 8'h78;
  localparam logic [FRAME_BITS-1:0] CODE_BAD_PREV   = 8'hF9;
  localparam logic [FRAME_BITS-1:0] CODE_OVERFLOW   = 8'hFA;
  localparam logic [FRAME_BITS-1:0] CODE_SELF_FAIL  = 8'hFC;
  localparam logic [FRAME_BITS-1:0] CODE_PWR_BEGIN  = 8'hFD;
  localparam logic [FRAME_BITS-1:0] CODE_PWR_END    = 8'hFE;

  typedef enum logic {
    ST_RECV = 1'b0,
    ST_ACK  = 1'b1
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;    // take one serial bit
    logic frameDone;  // this bit completes the byte
  } rxStrobe_t;

  // inverse then rotate right by one
  function automatic logic [FRAME_BITS-1:0] recoverEvent(input logic [FRAME_BITS-1:0] raw);
    logic [FRAME_BITS-1:0] inv;
    inv = ~raw;
    return {inv[0], inv[FRAME_BITS-1:1]};
  endfunction

  function automatic logic isStatus(input logic [FRAME_BITS-1:0] ev);
    logic hit;
    case (ev)
      CODE_RESET_WARN, CODE_BAD_PREV, CODE_OVERFLOW,
      CODE_SELF_FAIL, CODE_PWR_BEGIN, CODE_PWR_END: hit = 1'b1;
      default:                                      hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/kbd_rx_ctrl.sv
module kbd_rx_ctrl
  import kbd_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ACK_CYCLES  = 10625
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      kbClkIn,
  input  logic      kbDatIn,
  output rxStrobe_t strobe,
  output logic      datSync,
  output logic      ackActive
);

  localparam int ACK_W = $clog2(ACK_CYCLES + 1);

  logic [SYNC_STAGES-1:0] clkSync;
  logic [SYNC_STAGES-1:0] datSyncR;
  logic                   clkPrev;
  logic                   clkRise;
  logic [BIT_CNT_W-1:0]   bitCnt;
  logic [ACK_W-1:0]       ackCnt;
  rxState_t               state;

  // idle-high line: reset to 1 so release gives no false edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSync  <= '1;
      datSyncR <= '1;
      clkPrev  <= 1'b1;
    end else begin
      clkSync  <= {clkSync[SYNC_STAGES-2:0], kbClkIn};
      datSyncR <= {datSyncR[SYNC_STAGES-2:0], kbDatIn};
      clkPrev  <= clkSync[SYNC_STAGES-1];
    end
  end

  assign clkRise = clkSync[SYNC_STAGES-1] & ~clkPrev;
  assign datSync = datSyncR[SYNC_STAGES-1];

  always_comb begin
    strobe           = '0;
    strobe.shiftEn   = (state == ST_RECV) && clkRise;
    strobe.frameDone = strobe.shiftEn && (bitCnt == BIT_CNT_W'(FRAME_BITS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_RECV;
      bitCnt <= '0;
      ackCnt <= '0;
    end else begin
      case (state)
        ST_RECV: begin
          if (strobe.shiftEn) begin
            bitCnt <= strobe.frameDone ? '0 : bitCnt + 1'b1;
          end
          if (strobe.frameDone) begin
            state  <= ST_ACK;
            ackCnt <= ACK_W'(ACK_CYCLES - 1);
          end
        end
        ST_ACK: begin
          if (ackCnt == '0) begin
            state <= ST_RECV;
          end else begin
            ackCnt <= ackCnt - 1'b1;
          end
        end
        default: state <= ST_RECV;
      endcase
    end
  end

  assign ackActive = (state == ST_ACK);

endmodule

// File: rtl/kbd_rx_datapath.sv
module kbd_rx_datapath
  import kbd_rx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  rxStrobe_t             strobe,
  input  logic                  datIn,
  output logic                  evtValid,
  output logic [KEY_CODE_W-1:0] evtCode,
  output logic                  evtRelease,
  output logic                  statValid,
  output logic [FRAME_BITS-1:0] statCode,
  output logic [NUM_KEYS-1:0]   keyMatrix,
  output logic                  resetPending
);

  logic [FRAME_BITS-1:0] shiftReg;
  logic [FRAME_BITS-1:0] nextByte;
  logic [FRAME_BITS-1:0] evByte;
  logic                  evIsStatus;
  logic                  keyUpd;

  assign nextByte   = {shiftReg[FRAME_BITS-2:0], datIn};
  assign evByte     = recoverEvent(nextByte);
  assign evIsStatus = isStatus(evByte);
  assign keyUpd     = strobe.frameDone && !evIsStatus;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg     <= '0;
      evtValid     <= 1'b0;
      statValid    <= 1'b0;
      evtCode      <= '0;
      evtRelease   <= 1'b0;
      statCode     <= '0;
      resetPending <= 1'b0;
    end else begin
      if (strobe.shiftEn) begin
        shiftReg <= nextByte;
      end
      evtValid  <= keyUpd;
      statValid <= strobe.frameDone && evIsStatus;
      if (keyUpd) begin
        evtCode    <= evByte[KEY_CODE_W-1:0];
        evtRelease <= evByte[FRAME_BITS-1];
      end
      if (strobe.frameDone && evIsStatus) begin
        statCode <= evByte;
        if (evByte == CODE_RESET_WARN) begin
          resetPending <= 1'b1;
        end
      end
    end
  end

  // one flop per key code
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    always_ff @(posedge clk) begin
      if (!rstN) begin
        keyMatrix[k] <= 1'b0;
      end else if (keyUpd && (evByte[KEY_CODE_W-1:0] == KEY_CODE_W'(k))) begin
        keyMatrix[k] <= ~evByte[FRAME_BITS-1];
      end
    end
  end

endmodule

// File: rtl/kbd_rx.sv
module kbd_rx
  import kbd_rx_pkg::*;
#(
  parameter int CLK_KHZ     = 125000,
  parameter int ACK_US      = 85,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  kbClkIn,
  input  logic                  kbDatIn,
  output logic                  kbDatLow,
  output logic                  evtValid,
  output logic [KEY_CODE_W-1:0] evtCode,
  output logic                  evtRelease,
  output logic                  statValid,
  output logic [FRAME_BITS-1:0] statCode,
  output logic [NUM_KEYS-1:0]   keyMatrix,
  output logic                  resetPending
);

  localparam int ACK_CYCLES = (CLK_KHZ * ACK_US) / 1000;

  rxStrobe_t strobe;
  logic      datSync;

  kbd_rx_ctrl #(
    .SYNC_STAGES (SYNC_STAGES),
    .ACK_CYCLES  (ACK_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .kbClkIn   (kbClkIn),
    .kbDatIn   (kbDatIn),
    .strobe    (strobe),
    .datSync   (datSync),
    .ackActive (kbDatLow)
  );

  kbd_rx_datapath u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .datIn        (datSync),
    .evtValid     (evtValid),
    .evtCode      (evtCode),
    .evtRelease   (evtRelease),
    .statValid    (statValid),
    .statCode     (statCode),
    .keyMatrix    (keyMatrix),
    .resetPending (resetPending)
  );

endmodule

// File: rtl/kbd_rx_checker.sv
module kbd_rx_checker
  import kbd_rx_pkg::*;
#(
  parameter int ACK_CYCLES = 10625
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  kbDatLow,
  input logic                  evtValid,
  input logic [KEY_CODE_W-1:0] evtCode,
  input logic                  evtRelease,
  input logic                  statValid,
  input logic [FRAME_BITS-1:0] statCode,
  input logic [NUM_KEYS-1:0]   keyMatrix,
  input logic                  resetPending
);

  localparam int CNT_W = $clog2(ACK_CYCLES + 1) + 1;

  logic [CNT_W-1:0] lowRun;

  always_ff @(posedge clk) begin
    if (!rstN)         lowRun <= '0;
    else if (kbDatLow) lowRun <= lowRun + 1'b1;
    else               lowRun <= '0;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(evtValid && statValid)); // R5

  AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |=> !evtValid); // R3

  AST_ACK_WITH_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid || statValid) |-> kbDatLow); // R7

  AST_ACK_NOT_LONG: assert property (@(posedge clk) disable iff (!rstN)
    kbDatLow |-> (lowRun < CNT_W'(ACK_CYCLES))); // R7

  AST_ACK_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(kbDatLow) |-> (lowRun == CNT_W'(ACK_CYCLES))); // R7

  AST_PRESS_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !evtRelease) |-> keyMatrix[evtCode]); // R4

  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtRelease) |-> !keyMatrix[evtCode]); // R4

  AST_MATRIX_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !evtValid |-> $stable(keyMatrix)); // R5

  AST_WARN_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (statValid && statCode == CODE_RESET_WARN) |-> resetPending); // R6

  AST_PENDING_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    resetPending |=> resetPending); // R6

endmodule

bind kbd_rx kbd_rx_checker #(.ACK_CYCLES(ACK_CYCLES)) u_kbdRxChk (
  .clk          (clk),
  .rstN         (rstN),
  .kbDatLow     (kbDatLow),
  .evtValid     (evtValid),
  .evtCode      (evtCode),
  .evtRelease   (evtRelease),
  .statValid    (statValid),
  .statCode     (statCode),
  .keyMatrix    (keyMatrix),
  .resetPending (resetPending)
);

// File: tb/kbd_rx_bench.sv
`timescale 1ns/1ps
module kbd_rx_bench;

  localparam int CLK_KHZ = 125000;
  localparam int ACK_US  = 2;
  localparam int ACK_EXP = (CLK_KHZ * ACK_US) / 1000;  // 250 cycles
  localparam int NVEC    = 14;

  // {expect status, event byte}
  localparam logic [8:0] VECS [NVEC] = '{
    {1'b0, 8'h45}, {1'b0, 8'h20}, {1'b0, 8'hC5}, {1'b0, 8'h7F},
    {1'b0, 8'hFF}, {1'b0, 8'h00}, {1'b1, 8'hF9}, {1'b1, 8'hFA},
    {1'b1, 8'hFC}, {1'b1, 8'hFD}, {1'b1, 8'hFE}, {1'b0, 8'h7B},
    {1'b0, 8'hFB}, {1'b0, 8'h80}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         kbClkIn = 1'b1;
  logic         kbDatIn = 1'b1;
  logic         kbDatLow;
  logic         evtValid;
  logic [6:0]   evtCode;
  logic         evtRelease;
  logic         statValid;
  logic [7:0]   statCode;
  logic [127:0] keyMatrix;
  logic         resetPending;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [127:0] expMatrix = '0;
  logic         gotEvt, gotStat, gotRel, gotEarly;
  logic [6:0]   gotCode;
  logic [7:0]   gotStatCode;
  logic         gotAckStart;
  int           ackLen;

  always #4 clk = ~clk;

  kbd_rx #(.CLK_KHZ(CLK_KHZ), .ACK_US(ACK_US)) u_kbd_rx (
    .clk(clk), .rstN(rstN), .kbClkIn(kbClkIn), .kbDatIn(kbDatIn),
    .kbDatLow(kbDatLow), .evtValid(evtValid), .evtCode(evtCode),
    .evtRelease(evtRelease), .statValid(statValid), .statCode(statCode),
    .keyMatrix(keyMatrix), .resetPending(resetPending)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // send a raw wire byte, MSB first; capture results at the due cycle
  task automatic sendRaw(input logic [7:0] raw, input bit noisy);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      kbClkIn = 1'b0;
      kbDatIn = raw[i];
      repeat (4) @(negedge clk);
      kbClkIn = 1'b1;
      if (i > 0) repeat (4) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    gotEarly = evtValid | statValid;
    @(negedge clk);
    gotEvt = evtValid; gotStat = statValid; gotCode = evtCode;
    gotRel = evtRelease; gotStatCode = statCode; gotAckStart = kbDatLow;
    ackLen = 0;
    while (kbDatLow && ackLen < 100000) begin
      ackLen++;
      if (noisy) kbClkIn = (ackLen < ACK_EXP - 20) ? ackLen[2] : 1'b1;
      @(negedge clk);
    end
    kbClkIn = 1'b1;
    kbDatIn = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendEvent(input logic [7:0] ev, input bit noisy);
    sendRaw(~{ev[6:0], ev[7]}, noisy);
  endtask

  task automatic checkFrame(input logic [7:0] ev, input bit expStat);
    check(!gotEarly, "R3 strobe early", gotEarly, 0);
    check(gotEvt == !expStat, "R3 R5 evtValid", gotEvt, !expStat);
    check(gotStat == expStat, "R5 statValid", gotStat, expStat);
    if (!expStat) begin
      check(gotCode == ev[6:0], "R2 R3 evtCode", gotCode, ev[6:0]);
      check(gotRel == ev[7], "R3 evtRelease", gotRel, ev[7]);
      expMatrix[ev[6:0]] = ~ev[7];
    end else begin
      check(gotStatCode == ev, "R5 statCode", gotStatCode, ev);
    end
    check(keyMatrix == expMatrix, "R4 R5 R9 keyMatrix", keyMatrix, expMatrix);
    check(gotAckStart, "R7 ack start", gotAckStart, 1);
    check(ackLen == ACK_EXP, "R7 ack length", ackLen, ACK_EXP);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (5) @(negedge clk);
    check(!evtValid && !statValid && !kbDatLow, "R1 strobes in reset", {evtValid, statValid, kbDatLow}, 0);
    check(keyMatrix == '0 && !resetPending, "R1 matrix in reset", keyMatrix, 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check(!evtValid && !statValid && !kbDatLow && !resetPending, "R1 idle after reset",
          {evtValid, statValid, kbDatLow, resetPending}, 0);

    // table walk: R2 R3 R4 R5 R7 R9
    for (int v = 0; v < NVEC; v++) begin
      sendEvent(VECS[v][7:0], 1'b0);
      checkFrame(VECS[v][7:0], VECS[v][8]);
      check(!resetPending, "R6 no pending before warning", resetPending, 0);
    end

    // R8: serial clock toggles during the handshake are ignored
    sendEvent(8'h33, 1'b1);
    checkFrame(8'h33, 1'b0);
    sendEvent(8'h21, 1'b0);
    checkFrame(8'h21, 1'b0);
    check(gotCode == 7'h21, "R8 frame after noisy ack", gotCode, 7'h21);

    // R6: reset warning is sticky
    sendEvent(8'h78, 1'b0);
    checkFrame(8'h78, 1'b1);
    check(resetPending, "R6 pending set", resetPending, 1);
    sendEvent(8'hB3, 1'b0);
    checkFrame(8'hB3, 1'b0);
    check(resetPending, "R6 pending sticky", resetPending, 1);

    // R9: 0xF8 is a release of code 0x78, not a status
    sendEvent(8'h78 & 8'h7F, 1'b0);  // 0x78 again: status
    checkFrame(8'h78, 1'b1);
    sendEvent(8'hF8, 1'b0);
    checkFrame(8'hF8, 1'b0);

    // R1: reset mid-operation clears everything
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(keyMatrix == '0 && !resetPending && !kbDatLow, "R1 reset clears state",
          {keyMatrix, resetPending}, 0);
    rstN = 1'b1;
    expMatrix = '0;
    repeat (5) @(negedge clk);
    sendEvent(8'h50, 1'b0);
    checkFrame(8'h50, 1'b0);
    check(!resetPending, "R6 cleared only by reset", resetPending, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule